// File: doc/BRIEF.md
# Lockable Device Identifier Register Bank

This block keeps a 64-bit device identifier inside a configuration register space. The identifier is split into a low and a high 32-bit doubleword, and each of its eight bytes has its own byte address on a byte-wide reconfiguration port. That port carries an address, write data, a write strobe, a read strobe and registered read data.

A control byte at a separate address holds a single unlock bit. While the bit is clear, the identifier can be read but not written. While it is set, the identifier bytes accept writes one byte at a time. The normal update sequence sets the unlock bit, writes the eight identifier bytes, and then clears the unlock bit again. Two compile-time switches decide whether the capability is present at all and whether write access is ever permitted. A third parameter gives the value the identifier takes at reset. The full identifier is also driven on a parallel output, so that other logic can follow it directly.

Top module: `serial_id_regs`

## Requirements
- R1: After reset the identifier equals the reset-value parameter (default all zeros), and the unlock bit is 0.
- R2: The low doubleword bits [7:0], [15:8], [23:16] and [31:24] sit at byte addresses 0x168, 0x169, 0x16A and 0x16B. The high doubleword uses 0x16C to 0x16F in the same byte order.
- R3: Read data is valid on the clock after the read strobe, and it holds until the next read.
- R4: Bit 0 of the control byte at address 0x8BC is the unlock bit. Bits [7:1] read as 0 and ignore writes.
- R5: A write to an identifier byte while the unlock bit is 0 leaves the identifier unchanged, and no error is signalled.
- R6: A write to an identifier byte while the unlock bit is 1 replaces only that byte.
- R7: When write access is disabled by parameter, identifier writes never take effect, whatever the unlock bit holds.
- R8: When the capability is disabled by parameter, the identifier bytes read as zero and ignore writes.
- R9: A read of an unmapped address returns zero.
- R10: The parallel identifier output shows a byte update on the clock after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr | input | ADDR_W | Byte address |
| cfg_wdata | input | 8 | Write data |
| cfg_wr | input | 1 | Write strobe |
| cfg_rd | input | 1 | Read strobe |
| cfg_rdata | output | 8 | Registered read data |
| serial_id | output | 64 | Current identifier |

## Verification
The identifier is first written with a distinct value in every byte while locked, and then again while unlocked. A swapped address mapping, a wrong lane order, or a lock that does not hold each gives a different readback. Single-byte writes that leave the neighbouring bytes unchanged show that byte enables are separate. Writes of all ones to the control byte and reads of addresses next to the mapped window show that stray bits and decode aliasing are caught. Instances with the capability disabled and with write access disabled check the parameter variants against the same stimulus.

// File: rtl/serial_id_regs.sv
module serial_id_regs #(
  parameter int          ADDR_W     = 12,
  parameter bit          CAP_EN     = 1'b1,
  parameter bit          WR_EN      = 1'b1,
  parameter logic [31:0] RST_LO     = 32'h0,
  parameter logic [31:0] RST_HI     = 32'h0,
  parameter int          ID_BASE    = 'h168,
  parameter int          CTRL_ADDR  = 'h8BC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  output logic [7:0]        cfg_rdata,
  output logic [63:0]       serial_id
);
  localparam int NBYTES = 8;
  localparam logic [63:0] RST_ID = {RST_HI, RST_LO};

  logic [63:0] id_q;
  logic        unlock_q;
  logic        in_win;
  logic [2:0]  lane;
  logic        ctrl_hit;
  logic [7:0]  rd_mux;

  assign in_win   = CAP_EN && (cfg_addr >= ADDR_W'(ID_BASE)) &&
                    (cfg_addr < ADDR_W'(ID_BASE + NBYTES));
  assign lane     = 3'(cfg_addr - ADDR_W'(ID_BASE));
  assign ctrl_hit = (cfg_addr == ADDR_W'(CTRL_ADDR));

  always_ff @(posedge clk) begin
    if (!rst_n) unlock_q <= 1'b0;
    else if (cfg_wr && ctrl_hit) unlock_q <= cfg_wdata[0];
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    if (CAP_EN) begin : g_store
      always_ff @(posedge clk) begin
        if (!rst_n) id_q[8*b +: 8] <= RST_ID[8*b +: 8];
        else if (WR_EN && unlock_q && cfg_wr && in_win && lane == 3'(b))
          id_q[8*b +: 8] <= cfg_wdata;
      end
    end else begin : g_none
      assign id_q[8*b +: 8] = 8'h00;
    end
  end

  always_comb begin
    rd_mux = 8'h00;
    if (in_win) rd_mux = id_q[8*lane +: 8];
    else if (ctrl_hit) rd_mux = {7'b0, unlock_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_rdata <= 8'h00;
    else if (cfg_rd) cfg_rdata <= rd_mux;
  end

  assign serial_id = id_q;
endmodule

// File: rtl/serial_id_regs_chk.sv
module serial_id_regs_chk #(
  parameter int ADDR_W    = 12,
  parameter bit CAP_EN    = 1'b1,
  parameter bit WR_EN     = 1'b1,
  parameter int CTRL_ADDR = 'h8BC
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [7:0]        cfg_wdata,
  input logic              cfg_wr,
  input logic              cfg_rd,
  input logic [7:0]        cfg_rdata,
  input logic [63:0]       serial_id,
  input logic              unlock_q
);
  // R5
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !unlock_q |=> $stable(serial_id));
  // R7
  no_wr_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !WR_EN |=> $stable(serial_id));
  // R8
  cap_off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !CAP_EN |-> serial_id == 64'h0);
  // R3
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rd |=> $stable(cfg_rdata));
  // R4
  ctrl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && cfg_addr == ADDR_W'(CTRL_ADDR)) |=> cfg_rdata[7:1] == 7'h0);
  // R6
  one_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(serial_id ^ $past(serial_id)) > 0 |->
      $past(cfg_wr) && $past(unlock_q));
endmodule

bind serial_id_regs serial_id_regs_chk #(
  .ADDR_W(ADDR_W), .CAP_EN(CAP_EN), .WR_EN(WR_EN), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
  .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_rdata(cfg_rdata),
  .serial_id(serial_id), .unlock_q(unlock_q)
);

// File: tb/tb_serial_id_regs.sv
module tb_serial_id_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  rdata, rdata_nc, rdata_nw;
  logic [63:0] sid, sid_nc, sid_nw;
  int compared = 0, mismatched = 0;

  always #2 clk = ~clk;

  serial_id_regs #(.RST_LO(32'h0), .RST_HI(32'h0)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_addr(addr), .cfg_wdata(wdata),
    .cfg_wr(wr), .cfg_rd(rd), .cfg_rdata(rdata), .serial_id(sid));
  serial_id_regs #(.CAP_EN(1'b0)) dut_nc (
    .clk(clk), .rst_n(rst_n), .cfg_addr(addr), .cfg_wdata(wdata),
    .cfg_wr(wr), .cfg_rd(rd), .cfg_rdata(rdata_nc), .serial_id(sid_nc));
  serial_id_regs #(.WR_EN(1'b0), .RST_LO(32'h89ABCDEF), .RST_HI(32'h01234567)) dut_nw (
    .clk(clk), .rst_n(rst_n), .cfg_addr(addr), .cfg_wdata(wdata),
    .cfg_wr(wr), .cfg_rd(rd), .cfg_rdata(rdata_nw), .serial_id(sid_nw));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_byte(int a, logic [7:0] d);
    @(negedge clk); addr = 12'(a); wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_byte(int a);
    @(negedge clk); addr = 12'(a); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 id", sid, 64'h0);
    check("R1 nw reset value", sid_nw, 64'h01234567_89ABCDEF);
    rd_byte('h8BC);
    check("R1 unlock", 64'(rdata), 64'h0);
  endtask

  task automatic t_locked();
    for (int i = 0; i < 8; i++) wr_byte('h168 + i, 8'hA0 + 8'(i));
    check("R5 locked write", sid, 64'h0);
  endtask

  task automatic t_ctrl();
    wr_byte('h8BC, 8'hFF);
    rd_byte('h8BC);
    check("R4 ctrl readback", 64'(rdata), 64'h01);
  endtask

  task automatic t_unlocked();
    for (int i = 0; i < 8; i++) wr_byte('h168 + i, 8'h10 + 8'(i));
    check("R2 lane map", sid, 64'h17161514_13121110);
    for (int i = 0; i < 8; i++) begin
      rd_byte('h168 + i);
      check("R2 byte read", 64'(rdata), 64'(8'h10 + 8'(i)));
    end
  endtask

  task automatic t_single();
    @(negedge clk); addr = 12'h16D; wdata = 8'h5A; wr = 1'b1;
    @(posedge clk); #1;
    check("R10 parallel next clock", sid, 64'h17165A14_13121110);
    @(negedge clk); wr = 1'b0;
    check("R6 one byte", sid, 64'h17165A14_13121110);
  endtask

  task automatic t_hold();
    rd_byte('h16D);
    repeat (3) @(negedge clk);
    addr = 12'h168;
    @(negedge clk);
    check("R3 hold", 64'(rdata), 64'h5A);
  endtask

  task automatic t_unmapped();
    rd_byte('h167); check("R9 below window", 64'(rdata), 64'h0);
    rd_byte('h170); check("R9 above window", 64'(rdata), 64'h0);
    rd_byte('h000); check("R9 zero addr", 64'(rdata), 64'h0);
  endtask

  task automatic t_relock();
    wr_byte('h8BC, 8'h00);
    wr_byte('h168, 8'hEE);
    check("R5 relock", sid, 64'h17165A14_13121110);
  endtask

  task automatic t_variants();
    check("R8 cap off id", sid_nc, 64'h0);
    rd_byte('h16B);
    check("R8 cap off read", 64'(rdata_nc), 64'h0);
    check("R7 no write access", sid_nw, 64'h01234567_89ABCDEF);
    rd_byte('h16F);
    check("R7 nw readback", 64'(rdata_nw), 64'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_locked();
    t_ctrl();
    t_unlocked();
    t_single();
    t_hold();
    t_unmapped();
    t_variants();
    t_relock();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #40000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule